// File: doc/BRIEF.md
# Strip and Crossing Hit Histogrammer

This block builds monitoring histograms for the strips of one readout board. Every strip has two saturating counters. The first, the all-hits bank, counts every hit on that strip. The second, the windowed bank, counts a hit only when the hit's sub-crossing timing code falls inside a programmable window. A separate accumulator adds up the hits on all strips during one bunch crossing. At each crossing boundary the accumulated value is pushed into a FIFO and the accumulator starts again.

Slow control reads the counter banks through a one-cycle registered read port and drains the FIFO one entry at a time. None of this is time-critical. A run-control input gates all counting and pushing. A clear input zeroes both banks, the FIFO, the accumulator and the overflow flag.

Top module: `strip_xing_hist`

## Requirements
- R1: While `runEn` is high and `clearReq` is low, the all-hits counter of strip s goes up by one in every cycle where `hitVec[s]` is high. Any number of strips can be counted in the same cycle.
- R2: The windowed counter of strip s goes up only when strip s is counted under R1 and its code `hitSub[s*SUB_W +: SUB_W]` satisfies `winLo <= code <= winHi`, both ends included. When `winLo > winHi`, nothing is counted in the windowed bank.
- R3: Every per-strip counter stops at all ones and never wraps. The crossing accumulator saturates at all ones in the same way.
- R4: While `runEn` is low, no counter changes and no FIFO push happens, whatever `hitVec` and `xingStrobe` do.
- R5: A cycle with `xingStrobe` high marks the first cycle of a new crossing. In that cycle the FIFO receives the summed hit population of all counted cycles since the previous strobe. The strobe cycle's own hits start the new sum.
- R6: The FIFO is first-in first-out. `fifoData` shows the oldest entry, or 0 when the FIFO is empty. A `popReq` cycle removes that entry. A pop on an empty FIFO is ignored.
- R7: A push that arrives while the FIFO holds `FIFO_DEPTH` entries is dropped and sets `fifoOvf`. `fifoOvf` stays high until a clear.
- R8: A `clearReq` cycle zeroes both banks, empties the FIFO, resets the accumulator and drops `fifoOvf`. Clear wins over counting in the same cycle. Reset leaves the block in the same state.
- R9: When `rdEn` is high, `rdData` takes the counter of strip `rdAddr` from the next clock edge on. `rdBank` 0 selects the all-hits bank and 1 selects the windowed bank. An address at or above `NUM_STRIPS` reads 0. Without `rdEn`, `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run control; counting and pushing only while high |
| clearReq | input | 1 | Clear banks, FIFO, accumulator and overflow flag |
| hitVec | input | NUM_STRIPS | One hit flag per strip |
| hitSub | input | NUM_STRIPS*SUB_W | Sub-crossing code of each strip, strip s at bits s*SUB_W |
| xingStrobe | input | 1 | First cycle of a new crossing |
| winLo | input | SUB_W | Lowest code inside the window |
| winHi | input | SUB_W | Highest code inside the window |
| rdEn | input | 1 | Read request |
| rdBank | input | 1 | 0 all-hits bank, 1 windowed bank |
| rdAddr | input | ADDR_W | Strip index to read |
| rdData | output | CNT_W | Registered counter value |
| popReq | input | 1 | Remove the FIFO head |
| fifoData | output | XING_W | FIFO head, 0 when empty |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoOvf | output | 1 | Sticky flag for a dropped crossing total |

## Verification
The hardest states to reach from the ports are the saturation points and the window edges, because a 32-bit counter never fills in a practical run. The bench therefore shrinks the block to 6 strips, 4-bit counters, an 8-bit accumulator and a 4-entry FIFO. It then sweeps all 256 window settings. In each setting every strip sees each of the 16 codes once, so every window edge is crossed, the all-hits counters saturate, and the full-range window saturates too. FIFO overflow comes from strobing more often than the bench pops, and accumulator saturation comes from a long crossing with every strip hit.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Strobes the control module hands to the datapath each cycle.
  typedef struct packed {
    logic countEn;   // counting allowed this cycle
    logic clearAll;  // zero banks, FIFO and accumulator
    logic xingMark;  // counted crossing boundary
    logic push;      // write accumulator into FIFO
    logic pop;       // advance FIFO head
  } histStrobes_t;
endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEn,
  input  logic         clearReq,
  input  logic         xingStrobe,
  input  logic         popReq,
  input  logic         fifoFull,
  input  logic         fifoEmpty,
  output histStrobes_t st,
  output logic         fifoOvf
);
  always_comb begin
    st.clearAll = clearReq;
    st.countEn  = runEn & ~clearReq;
    st.xingMark = runEn & ~clearReq & xingStrobe;
    st.push     = st.xingMark & ~fifoFull;
    st.pop      = popReq & ~fifoEmpty & ~clearReq;
  end

  // Sticky overflow: set by a dropped push, removed only by clear.
  always_ff @(posedge clk) begin
    if (!rstN)                          fifoOvf <= 1'b0;
    else if (clearReq)                  fifoOvf <= 1'b0;
    else if (st.xingMark && fifoFull)   fifoOvf <= 1'b1;
  end
endmodule

// File: rtl/hist_datapath.sv
module hist_datapath
  import hist_pkg::*;
#(
  parameter int NUM_STRIPS = 96,
  parameter int CNT_W      = 32,
  parameter int SUB_W      = 4,
  parameter int XING_W     = 32,
  parameter int FIFO_DEPTH = 128,
  parameter int ADDR_W     = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  histStrobes_t                st,
  input  logic [NUM_STRIPS-1:0]       hitVec,
  input  logic [NUM_STRIPS*SUB_W-1:0] hitSub,
  input  logic [SUB_W-1:0]            winLo,
  input  logic [SUB_W-1:0]            winHi,
  input  logic                        rdEn,
  input  logic                        rdBank,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [CNT_W-1:0]            rdData,
  output logic [XING_W-1:0]           fifoData,
  output logic                        fifoEmpty,
  output logic                        fifoFull
);
  localparam int PC_W  = $clog2(NUM_STRIPS + 1);
  localparam int SUM_W = XING_W + 1;
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [ADDR_W:0]   STRIP_LIM = (ADDR_W + 1)'(NUM_STRIPS);
  localparam logic [PTR_W-1:0]  PTR_LAST  = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [LVL_W-1:0]  LVL_FULL  = LVL_W'(FIFO_DEPTH);

  logic [NUM_STRIPS-1:0][CNT_W-1:0] fullFlat;
  logic [NUM_STRIPS-1:0][CNT_W-1:0] winFlat;

  // ---------------- per-strip counter pairs ----------------
  for (genvar s = 0; s < NUM_STRIPS; s++) begin : g_strip
    logic [SUB_W-1:0] code;
    logic             inWin;
    logic [CNT_W-1:0] fullCnt;
    logic [CNT_W-1:0] winCnt;

    assign code  = hitSub[s*SUB_W +: SUB_W];
    assign inWin = (code >= winLo) && (code <= winHi);

    always_ff @(posedge clk) begin
      if (!rstN || st.clearAll) begin
        fullCnt <= '0;
        winCnt  <= '0;
      end else if (st.countEn && hitVec[s]) begin
        if (fullCnt != CNT_MAX)          fullCnt <= fullCnt + CNT_W'(1);
        if (inWin && winCnt != CNT_MAX)  winCnt  <= winCnt + CNT_W'(1);
      end
    end

    assign fullFlat[s] = fullCnt;
    assign winFlat[s]  = winCnt;
  end

  // ---------------- register read port ----------------
  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn) begin
      if ({1'b0, rdAddr} < STRIP_LIM)
        rdData <= rdBank ? winFlat[rdAddr] : fullFlat[rdAddr];
      else
        rdData <= '0;
    end
  end

  // ---------------- per-crossing accumulator ----------------
  logic [PC_W-1:0]   hitCount;
  logic [SUM_W-1:0]  accSum;
  logic [XING_W-1:0] accNext;
  logic [XING_W-1:0] xingAcc;

  always_comb begin
    hitCount = PC_W'($countones(hitVec));
    accSum   = {1'b0, xingAcc} + SUM_W'(hitCount);
    accNext  = accSum[XING_W] ? '1 : accSum[XING_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clearAll) xingAcc <= '0;
    else if (st.xingMark)     xingAcc <= XING_W'(hitCount);
    else if (st.countEn)      xingAcc <= accNext;
  end

  // ---------------- crossing-total FIFO ----------------
  logic [XING_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [LVL_W-1:0]  level;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (st.push) fifoMem[wrPtr] <= xingAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clearAll) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (st.push) wrPtr <= bump(wrPtr);
      if (st.pop)  rdPtr <= bump(rdPtr);
      case ({st.push, st.pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level == LVL_FULL);
  assign fifoData  = fifoEmpty ? '0 : fifoMem[rdPtr];
endmodule

// File: rtl/strip_xing_hist.sv
module strip_xing_hist
  import hist_pkg::*;
#(
  parameter int NUM_STRIPS = 96,
  parameter int CNT_W      = 32,
  parameter int SUB_W      = 4,
  parameter int XING_W     = 32,
  parameter int FIFO_DEPTH = 128,
  localparam int ADDR_W    = $clog2(NUM_STRIPS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        runEn,
  input  logic                        clearReq,
  input  logic [NUM_STRIPS-1:0]       hitVec,
  input  logic [NUM_STRIPS*SUB_W-1:0] hitSub,
  input  logic                        xingStrobe,
  input  logic [SUB_W-1:0]            winLo,
  input  logic [SUB_W-1:0]            winHi,
  input  logic                        rdEn,
  input  logic                        rdBank,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [CNT_W-1:0]            rdData,
  input  logic                        popReq,
  output logic [XING_W-1:0]           fifoData,
  output logic                        fifoEmpty,
  output logic                        fifoOvf
);
  histStrobes_t st;
  logic         fifoFull;

  hist_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .clearReq  (clearReq),
    .xingStrobe(xingStrobe),
    .popReq    (popReq),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .st        (st),
    .fifoOvf   (fifoOvf)
  );

  hist_datapath #(
    .NUM_STRIPS(NUM_STRIPS),
    .CNT_W     (CNT_W),
    .SUB_W     (SUB_W),
    .XING_W    (XING_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .hitVec   (hitVec),
    .hitSub   (hitSub),
    .winLo    (winLo),
    .winHi    (winHi),
    .rdEn     (rdEn),
    .rdBank   (rdBank),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .fifoData (fifoData),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull)
  );
endmodule

// File: rtl/hist_checker.sv
module hist_checker #(
  parameter int RD_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            runEn,
  input logic            clearReq,
  input logic            rdEn,
  input logic [RD_W-1:0] rdData,
  input logic            fifoEmpty,
  input logic            fifoFull,
  input logic            fifoOvf
);
  // R8: the cycle after a clear sees an empty FIFO and no overflow.
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (fifoEmpty && !fifoOvf));

  // R7: overflow stays set until a clear.
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOvf && !clearReq) |=> fifoOvf);

  // R7: overflow can only appear after the FIFO was full.
  p_ovf_needs_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoOvf) |-> $past(fifoFull));

  // R4: with run control low an empty FIFO stays empty.
  p_idle_keeps_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !runEn) |=> fifoEmpty);

  // R9: read data only moves on a read request.
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind strip_xing_hist hist_checker #(.RD_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .runEn    (runEn),
  .clearReq (clearReq),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .fifoEmpty(fifoEmpty),
  .fifoFull (fifoFull),
  .fifoOvf  (fifoOvf)
);

// File: tb/sim_strip_xing_hist.sv
`timescale 1ns/1ps
module sim_strip_xing_hist;
  localparam int NS = 6, CW = 4, SW = 4, XW = 8, FD = 4, AW = 3;
  localparam int CMAX = 15, XMAX = 255;

  logic clk = 0;
  logic rstN = 0, runEn = 0, clearReq = 0, xingStrobe = 0;
  logic [NS-1:0] hitVec = '0;
  logic [NS*SW-1:0] hitSub = '0;
  logic [SW-1:0] winLo = '0, winHi = '0;
  logic rdEn = 0, rdBank = 0, popReq = 0;
  logic [AW-1:0] rdAddr = '0;
  logic [CW-1:0] rdData;
  logic [XW-1:0] fifoData;
  logic fifoEmpty, fifoOvf;

  always #2 clk = ~clk;

  strip_xing_hist #(.NUM_STRIPS(NS), .CNT_W(CW), .SUB_W(SW), .XING_W(XW),
                    .FIFO_DEPTH(FD)) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  int subs [NS];
  int mFull [NS];
  int mWin [NS];
  int mAcc = 0, mHead = 0, mTail = 0, mOvf = 0;
  int mQ [64];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int s = 0; s < NS; s++) begin mFull[s] = 0; mWin[s] = 0; end
    mAcc = 0; mHead = 0; mTail = 0; mOvf = 0;
  endtask

  // One clock with the given hits; the model follows the requirements.
  task automatic tick(logic [NS-1:0] hv, bit strobe);
    hitVec = hv; xingStrobe = strobe;
    for (int s = 0; s < NS; s++) hitSub[s*SW +: SW] = subs[s][SW-1:0];
    if (clearReq) clearModel();
    else if (runEn) begin
      int pc;
      pc = 0;
      for (int s = 0; s < NS; s++) if (hv[s]) begin
        pc++;
        if (mFull[s] < CMAX) mFull[s]++;
        if (subs[s] >= int'(winLo) && subs[s] <= int'(winHi) && mWin[s] < CMAX) mWin[s]++;
      end
      if (strobe) begin
        if (mTail - mHead < FD) begin mQ[mTail % 64] = mAcc; mTail++; end
        else mOvf = 1;
        mAcc = pc;
      end else mAcc = (mAcc + pc > XMAX) ? XMAX : mAcc + pc;
    end
    @(negedge clk);
    hitVec = '0; xingStrobe = 0;
  endtask

  task automatic doClear();
    clearReq = 1; tick('1, 1); clearReq = 0;
  endtask

  task automatic rd(bit bank, int addr, output int v);
    rdEn = 1; rdBank = bank; rdAddr = addr[AW-1:0];
    @(negedge clk);
    rdEn = 0; v = int'(rdData);
  endtask

  task automatic checkBanks(string tagFull, string tagWin);
    int v;
    for (int s = 0; s < NS; s++) begin
      rd(0, s, v); chk(tagFull, v, mFull[s]);
      rd(1, s, v); chk(tagWin, v, mWin[s]);
    end
  endtask

  task automatic popChk(string tag);
    int e;
    e = (mTail > mHead) ? mQ[mHead % 64] : 0;
    chk(tag, int'(fifoData), e);
    popReq = 1; @(negedge clk); popReq = 0;
    if (mTail > mHead) mHead++;
  endtask

  initial begin
    int v;
    for (int s = 0; s < NS; s++) subs[s] = 0;
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);

    // R8: reset state
    checkBanks("R8 reset full bank", "R8 reset window bank");
    chk("R8 reset empty", fifoEmpty, 1);
    chk("R8 reset ovf", fifoOvf, 0);
    chk("R6 empty head reads 0", fifoData, 0);

    // R1, R2: varied hit patterns, window 2..9
    winLo = 2; winHi = 9; runEn = 1; doClear();
    for (int c = 0; c < 12; c++) begin
      for (int s = 0; s < NS; s++) subs[s] = (c * 3 + s * 5) % 16;
      tick(NS'((c * 11 + 5) % 64), 0);
    end
    checkBanks("R1 all-hits count", "R2 window count");

    // R4: stopped run ignores hits and strobes
    runEn = 0;
    for (int c = 0; c < 5; c++) tick('1, 1);
    checkBanks("R4 full held while stopped", "R4 window held while stopped");
    chk("R4 no push while stopped", fifoEmpty, 1);

    // R9: out-of-range address reads 0
    rd(0, 6, v); chk("R9 addr 6 full", v, 0);
    rd(1, 7, v); chk("R9 addr 7 window", v, 0);

    // R8: clear wins over counting in the same cycle
    runEn = 1; doClear();
    checkBanks("R8 clear full", "R8 clear window");

    // R2, R3: sweep every window; each strip sees every code once
    for (int lo = 0; lo < 16; lo++)
      for (int hi = 0; hi < 16; hi++) begin
        winLo = lo[SW-1:0]; winHi = hi[SW-1:0];
        doClear();
        for (int c = 0; c < 16; c++) begin
          for (int s = 0; s < NS; s++) subs[s] = (c + s) % 16;
          tick('1, 0);
        end
        checkBanks("R3 saturated full", "R2 window edge sweep");
      end

    // R5, R6: crossing totals in order
    doClear();
    for (int c = 0; c < 10; c++)
      tick(NS'((c * 13 + 7) % 64), (c == 2 || c == 5 || c == 9));
    chk("R5 pushes present", fifoEmpty, 0);
    for (int k = 0; k < 3; k++) popChk("R5 crossing total");
    chk("R6 empty after drain", fifoEmpty, 1);
    chk("R6 empty head zero", fifoData, 0);
    popChk("R6 pop on empty");
    chk("R6 still empty", fifoEmpty, 1);
    tick('0, 1);
    popChk("R6 value after empty pop");

    // R7: overflow drops and stays
    doClear();
    for (int c = 0; c < 14; c++) tick(NS'(c % 64), c % 2);
    chk("R7 ovf set", fifoOvf, mOvf);
    for (int k = 0; k < FD; k++) popChk("R7 kept entries");
    chk("R7 ovf sticky", fifoOvf, 1);
    chk("R7 drained", fifoEmpty, 1);
    doClear();
    chk("R8 clear drops ovf", fifoOvf, 0);
    chk("R8 clear empties", fifoEmpty, 1);

    // R3: accumulator saturation
    doClear();
    tick('0, 1); popChk("R5 first strobe after clear");
    for (int c = 0; c < 50; c++) tick('1, 0);
    tick('0, 1);
    popChk("R3 accumulator saturates");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule